// File: doc/BRIEF.md
# Debug Event Trigger Unit

This block observes three on-chip streams, the instruction pointer, the memory access address and the memory data bus, and turns what it sees into debug actions. It has three kinds of event source. Address windows fire when a watched value lies between a lower and an upper bound, with both bounds inclusive. Data matchers fire when the data bus equals a pattern on the bits a mask selects. Event counters step on a chosen event and pulse when they reach a programmed limit.

Counter pulses are registered and fed back into the same event set. A counter can therefore count another counter's pulses, or the AND of an address window with a data matcher. This gives multi-stage triggers such as "break on the third write of 0x55 inside a buffer". A single shared selection scheme drives a breakpoint pulse and a trace-enable level. All settings come through a write-only valid/address/data port. A clear input restarts every counter and drops trace-enable without touching the settings.

Top module: `dbg_evt_trigger`

## Requirements
- R1: Address window i fires in a cycle when its watched value v satisfies lower ≤ v ≤ upper and the valid strobe of that value is high. The watched value is the instruction pointer when mode bit 0 is 0 and the memory address when it is 1.
- R2: Data matcher j fires when `mdata_valid_i` is high and every data bit whose mask bit is 1 equals the pattern bit. Bits whose mask bit is 0 are ignored.
- R3: An 8-bit selector code picks an event. 0 means none. Codes 1..NR are the windows. The next ND codes are the data matchers. The next NC codes are the counter pulses. For counters only, code NR+ND+NC+1 means window[a] AND matcher[d], with a and d taken from the counter control word. Codes outside these ranges mean no event.
- R4: A counter adds one in each cycle its selected event is high. Its limit pulse is high for the one cycle after the event that brings the count to the limit. A limit of 0 never pulses.
- R5: After its limit is reached, a counter with control bit 16 = 1 restarts from 0. With bit 16 = 0 it holds at the limit and pulses no more.
- R6: A counter that counts another counter's pulses sees each pulse one cycle after that pulse's own trigger, so each stage of a chain adds exactly one cycle.
- R7: When output-control bit 0 is 1, `brk_o` is high in the cycle after each cycle in which the event selected by output-control bits [15:8] is high. When bit 0 is 0, `brk_o` stays low.
- R8: `trace_o` goes high after the event selected by output-control bits [23:16] and low after the event selected by bits [31:24]. When both happen in the same cycle, it goes low.
- R9: A cycle with `clear_i` high sets every count to 0, drops pending limit pulses and sets `trace_o` low on the next cycle. The settings are left as they are.
- R10: The write address holds the register kind in bits [7:4] and the unit index in bits [3:0]. The kinds are 0 lower bound, 1 upper bound, 2 window mode, 3 data pattern, 4 data mask, 5 counter control (bits [7:0] source, [11:8] AND window, [15:12] AND matcher, [16] restart), 6 counter limit, and 7 output control (index 0). Every register resets to 0, so after reset `brk_o` and `trace_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ip_i | input | AW | Instruction pointer |
| ip_valid_i | input | 1 | Instruction pointer valid |
| maddr_i | input | AW | Memory access address |
| maddr_valid_i | input | 1 | Memory address valid |
| mdata_i | input | DW | Memory data bus |
| mdata_valid_i | input | 1 | Memory data valid |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register address (kind, index) |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| clear_i | input | 1 | Restart counters and drop trace enable |
| brk_o | output | 1 | Breakpoint pulse |
| trace_o | output | 1 | Trace qualification level |

## Verification
On every cycle, the assertions check the following. A window or matcher fires only while its valid strobe is high. A counter pulse always follows a cycle in which that counter's selected event was present. A breakpoint needs a prior enable. Trace-enable rises only after its set event and is low after a clear event or a global clear. Some behaviour can only be shown by the bench's scenarios, which run against expected results. This covers the exact inclusive bounds, the mask semantics, the count at which a limit pulses, hold versus restart, the zero limit, the one-cycle cost of each stage of a counter chain, and the AND combination.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

  localparam int unsigned SEL_W = 8;
  localparam int unsigned VEC_W = 64;

  localparam logic [3:0] K_RNG_LO  = 4'd0;
  localparam logic [3:0] K_RNG_HI  = 4'd1;
  localparam logic [3:0] K_RNG_MD  = 4'd2;
  localparam logic [3:0] K_DAT_PAT = 4'd3;
  localparam logic [3:0] K_DAT_MSK = 4'd4;
  localparam logic [3:0] K_CNT_CTL = 4'd5;
  localparam logic [3:0] K_CNT_LIM = 4'd6;
  localparam logic [3:0] K_OUT_CTL = 4'd7;

  function automatic logic in_window(input logic [63:0] v,
                                     input logic [63:0] lo,
                                     input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic masked_eq(input logic [63:0] d,
                                     input logic [63:0] pat,
                                     input logic [63:0] msk);
    return ((d ^ pat) & msk) == 64'd0;
  endfunction

  function automatic logic sel_pick(input logic [SEL_W-1:0] sel,
                                    input logic [VEC_W-1:0] vec,
                                    input int unsigned      nev);
    if (sel == '0 || int'(sel) > nev) return 1'b0;
    return vec[6'(sel - 8'd1)];
  endfunction

  function automatic logic idx_pick(input logic [VEC_W-1:0] vec,
                                    input logic [3:0]       idx,
                                    input int unsigned      n);
    if (int'(idx) >= n) return 1'b0;
    return vec[idx];
  endfunction

endpackage

// File: rtl/dbg_evt_window.sv
module dbg_evt_window #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ip_i,
  input  logic          ip_valid_i,
  input  logic [AW-1:0] maddr_i,
  input  logic          maddr_valid_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          on_mem_i,
  output logic          hit_o
);
  import dbg_evt_pkg::*;

  logic [AW-1:0] watched;
  logic          watched_v;

  always_comb begin
    watched   = on_mem_i ? maddr_i : ip_i;
    watched_v = on_mem_i ? maddr_valid_i : ip_valid_i;
    hit_o     = watched_v && in_window(64'(watched), 64'(lo_i), 64'(hi_i));
  end
endmodule

// File: rtl/dbg_evt_match.sv
module dbg_evt_match #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  input  logic [DW-1:0] pat_i,
  input  logic [DW-1:0] msk_i,
  output logic          hit_o
);
  import dbg_evt_pkg::*;

  always_comb hit_o = valid_i && masked_eq(64'(data_i), 64'(pat_i), 64'(msk_i));
endmodule

// File: rtl/dbg_evt_counter.sv
module dbg_evt_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          ev_i,
  input  logic [CW-1:0] limit_i,
  input  logic          restart_i,
  output logic          pulse_o
);
  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic          armed;
  logic          reach;

  always_comb begin
    armed = (limit_i != '0) && (cnt_q != limit_i);
    reach = (cnt_q + CW'(1)) == limit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (ev_i && armed) begin
        if (reach) begin
          pulse_q <= 1'b1;
          cnt_q   <= restart_i ? '0 : limit_i;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/dbg_evt_trigger.sv
module dbg_evt_trigger #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NR    = 2,
  parameter int unsigned ND    = 2,
  parameter int unsigned NC    = 2,
  parameter int unsigned CW    = 16,
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ip_i,
  input  logic             ip_valid_i,
  input  logic [AW-1:0]    maddr_i,
  input  logic             maddr_valid_i,
  input  logic [DW-1:0]    mdata_i,
  input  logic             mdata_valid_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             clear_i,
  output logic             brk_o,
  output logic             trace_o
);
  import dbg_evt_pkg::*;

  localparam int unsigned NEV     = NR + ND + NC;
  localparam int unsigned SEL_AND = NEV + 1;
  localparam int unsigned OFF_D   = NR;
  localparam int unsigned OFF_C   = NR + ND;

  logic [3:0] wr_kind;
  logic [3:0] wr_idx;
  assign wr_kind = cfg_addr_i[7:4];
  assign wr_idx  = cfg_addr_i[3:0];

  // settings
  logic [AW-1:0]    rng_lo_q  [NR];
  logic [AW-1:0]    rng_hi_q  [NR];
  logic             rng_mem_q [NR];
  logic [DW-1:0]    dat_pat_q [ND];
  logic [DW-1:0]    dat_msk_q [ND];
  logic [SEL_W-1:0] cnt_src_q [NC];
  logic [3:0]       cnt_ar_q  [NC];
  logic [3:0]       cnt_ad_q  [NC];
  logic             cnt_rs_q  [NC];
  logic [CW-1:0]    cnt_lim_q [NC];
  logic             brk_en_q;
  logic [SEL_W-1:0] brk_sel_q;
  logic [SEL_W-1:0] tr_set_q;
  logic [SEL_W-1:0] tr_clr_q;

  // named internal events
  logic [NR-1:0]    range_hit;
  logic [ND-1:0]    data_hit;
  logic [NC-1:0]    cnt_hit;
  logic [NC-1:0]    cnt_ev;
  logic [VEC_W-1:0] evt_all;
  logic             brk_ev;
  logic             tr_set_ev;
  logic             tr_clr_ev;
  logic             brk_q;
  logic             trace_q;

  for (genvar r = 0; r < NR; r++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_lo_q[r]  <= '0;
        rng_hi_q[r]  <= '0;
        rng_mem_q[r] <= 1'b0;
      end else if (cfg_we_i && int'(wr_idx) == r) begin
        if (wr_kind == K_RNG_LO) rng_lo_q[r]  <= cfg_wdata_i[AW-1:0];
        if (wr_kind == K_RNG_HI) rng_hi_q[r]  <= cfg_wdata_i[AW-1:0];
        if (wr_kind == K_RNG_MD) rng_mem_q[r] <= cfg_wdata_i[0];
      end
    end

    dbg_evt_window #(.AW(AW)) u_win (
      .ip_i          (ip_i),
      .ip_valid_i    (ip_valid_i),
      .maddr_i       (maddr_i),
      .maddr_valid_i (maddr_valid_i),
      .lo_i          (rng_lo_q[r]),
      .hi_i          (rng_hi_q[r]),
      .on_mem_i      (rng_mem_q[r]),
      .hit_o         (range_hit[r])
    );
  end

  for (genvar d = 0; d < ND; d++) begin : g_dat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_pat_q[d] <= '0;
        dat_msk_q[d] <= '0;
      end else if (cfg_we_i && int'(wr_idx) == d) begin
        if (wr_kind == K_DAT_PAT) dat_pat_q[d] <= cfg_wdata_i[DW-1:0];
        if (wr_kind == K_DAT_MSK) dat_msk_q[d] <= cfg_wdata_i[DW-1:0];
      end
    end

    dbg_evt_match #(.DW(DW)) u_match (
      .data_i  (mdata_i),
      .valid_i (mdata_valid_i),
      .pat_i   (dat_pat_q[d]),
      .msk_i   (dat_msk_q[d]),
      .hit_o   (data_hit[d])
    );
  end

  always_comb begin
    evt_all = '0;
    evt_all[OFF_D-1:0]  = range_hit;
    evt_all[OFF_D +: ND] = data_hit;
    evt_all[OFF_C +: NC] = cnt_hit;
  end

  for (genvar c = 0; c < NC; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_src_q[c] <= '0;
        cnt_ar_q[c]  <= '0;
        cnt_ad_q[c]  <= '0;
        cnt_rs_q[c]  <= 1'b0;
        cnt_lim_q[c] <= '0;
      end else if (cfg_we_i && int'(wr_idx) == c) begin
        if (wr_kind == K_CNT_CTL) begin
          cnt_src_q[c] <= cfg_wdata_i[7:0];
          cnt_ar_q[c]  <= cfg_wdata_i[11:8];
          cnt_ad_q[c]  <= cfg_wdata_i[15:12];
          cnt_rs_q[c]  <= cfg_wdata_i[16];
        end
        if (wr_kind == K_CNT_LIM) cnt_lim_q[c] <= cfg_wdata_i[CW-1:0];
      end
    end

    always_comb begin
      if (int'(cnt_src_q[c]) == SEL_AND)
        cnt_ev[c] = idx_pick(VEC_W'(range_hit), cnt_ar_q[c], NR)
                  & idx_pick(VEC_W'(data_hit),  cnt_ad_q[c], ND);
      else
        cnt_ev[c] = sel_pick(cnt_src_q[c], evt_all, NEV);
    end

    dbg_evt_counter #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clear_i),
      .ev_i      (cnt_ev[c]),
      .limit_i   (cnt_lim_q[c]),
      .restart_i (cnt_rs_q[c]),
      .pulse_o   (cnt_hit[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_en_q  <= 1'b0;
      brk_sel_q <= '0;
      tr_set_q  <= '0;
      tr_clr_q  <= '0;
    end else if (cfg_we_i && wr_kind == K_OUT_CTL && wr_idx == 4'd0) begin
      brk_en_q  <= cfg_wdata_i[0];
      brk_sel_q <= cfg_wdata_i[15:8];
      tr_set_q  <= cfg_wdata_i[23:16];
      tr_clr_q  <= cfg_wdata_i[31:24];
    end
  end

  always_comb begin
    brk_ev    = sel_pick(brk_sel_q, evt_all, NEV);
    tr_set_ev = sel_pick(tr_set_q,  evt_all, NEV);
    tr_clr_ev = sel_pick(tr_clr_q,  evt_all, NEV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q   <= 1'b0;
      trace_q <= 1'b0;
    end else begin
      brk_q <= brk_en_q && brk_ev;
      if (clear_i || tr_clr_ev) trace_q <= 1'b0;
      else if (tr_set_ev)       trace_q <= 1'b1;
    end
  end

  assign brk_o   = brk_q;
  assign trace_o = trace_q;
endmodule

// File: rtl/dbg_evt_trigger_chk.sv
module dbg_evt_trigger_chk #(
  parameter int unsigned NR = 2,
  parameter int unsigned ND = 2,
  parameter int unsigned NC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ip_valid,
  input logic          maddr_valid,
  input logic          mdata_valid,
  input logic          clear,
  input logic          brk,
  input logic          trace,
  input logic [NR-1:0] range_hit,
  input logic [ND-1:0] data_hit,
  input logic [NC-1:0] cnt_hit,
  input logic [NC-1:0] cnt_ev,
  input logic          brk_en,
  input logic          tr_set_ev,
  input logic          tr_clr_ev
);
  // R1
  window_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_hit != '0) |-> (ip_valid || maddr_valid));

  // R2
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit != '0) |-> mdata_valid);

  for (genvar c = 0; c < NC; c++) begin : g_c
    // R4
    pulse_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_hit[c] |-> $past(cnt_ev[c]));
  end

  // R7
  brk_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> $past(brk_en));

  // R8
  trace_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace) |-> $past(tr_set_ev));

  // R8
  trace_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_clr_ev |=> !trace);

  // R9
  global_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!trace && cnt_hit == '0));
endmodule

bind dbg_evt_trigger dbg_evt_trigger_chk #(.NR(NR), .ND(ND), .NC(NC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ip_valid    (ip_valid_i),
  .maddr_valid (maddr_valid_i),
  .mdata_valid (mdata_valid_i),
  .clear       (clear_i),
  .brk         (brk_o),
  .trace       (trace_o),
  .range_hit   (range_hit),
  .data_hit    (data_hit),
  .cnt_hit     (cnt_hit),
  .cnt_ev      (cnt_ev),
  .brk_en      (brk_en_q),
  .tr_set_ev   (tr_set_ev),
  .tr_clr_ev   (tr_clr_ev)
);

// File: tb/dbg_evt_trigger_tb_top.sv
module dbg_evt_trigger_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ip_i = '0;
  logic        ip_valid_i = 1'b0;
  logic [31:0] maddr_i = '0;
  logic        maddr_valid_i = 1'b0;
  logic [31:0] mdata_i = '0;
  logic        mdata_valid_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        clear_i = 1'b0;
  logic        brk_o;
  logic        trace_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_evt_trigger dut_i (
    .clk(clk), .rst_n(rst_n),
    .ip_i(ip_i), .ip_valid_i(ip_valid_i),
    .maddr_i(maddr_i), .maddr_valid_i(maddr_valid_i),
    .mdata_i(mdata_i), .mdata_valid_i(mdata_valid_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .clear_i(clear_i), .brk_o(brk_o), .trace_o(trace_o)
  );

  typedef struct {
    logic  b;
    logic  t;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic tr_model = 1'b0;
  bit   done = 1'b0;

  // monitor: one expected item per clock edge, sampled after the edge
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (brk_o !== e.b || trace_o !== e.t) begin
        n_fail++;
        $display("FAIL %s: brk=%0b trace=%0b expected brk=%0b trace=%0b",
                 e.tag, brk_o, trace_o, e.b, e.t);
      end
    end
  end

  function automatic logic [7:0] ra(input int kind, input int idx);
    return 8'((kind << 4) | idx);
  endfunction

  task automatic drive(input logic ipv, input logic [31:0] ip,
                       input logic av, input logic [31:0] a,
                       input logic dv, input logic [31:0] d,
                       input logic clr, input logic eb, input string tag);
    @(negedge clk);
    ip_valid_i = ipv; ip_i = ip;
    maddr_valid_i = av; maddr_i = a;
    mdata_valid_i = dv; mdata_i = d;
    clear_i = clr; cfg_we_i = 1'b0;
    q.push_back('{eb, tr_model, tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ip_valid_i = 0; maddr_valid_i = 0; mdata_valid_i = 0; clear_i = 0;
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    q.push_back('{1'b0, tr_model, "R10"});
  endtask

  task automatic t_ip(input logic [31:0] ip, input logic v, input logic eb, input string tag);
    drive(v, ip, 0, 0, 0, 0, 0, eb, tag);
  endtask
  task automatic t_addr(input logic [31:0] a, input logic eb, input string tag);
    drive(0, 0, 1, a, 0, 0, 0, eb, tag);
  endtask
  task automatic t_dat(input logic [31:0] d, input logic v, input logic eb, input string tag);
    drive(0, 0, 0, 0, v, d, 0, eb, tag);
  endtask
  task automatic t_ad(input logic [31:0] a, input logic [31:0] d, input logic eb, input string tag);
    drive(0, 0, 1, a, 1, d, 0, eb, tag);
  endtask
  task automatic t_idle(input logic eb, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, eb, tag);
  endtask
  task automatic t_clr(input string tag);
    tr_model = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: expected completion, run hung");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    n_chk++;
    if (brk_o !== 1'b0 || trace_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: brk=%0b trace=%0b expected brk=0 trace=0", brk_o, trace_o);
    end

    // R1 window on instruction pointer, inclusive bounds
    wr(ra(0,0), 32'h100);
    wr(ra(1,0), 32'h1FF);
    wr(ra(7,0), 32'h1 | (32'd1 << 8));
    t_ip(32'h0FF, 1, 0, "R1");
    t_ip(32'h100, 1, 1, "R1");
    t_ip(32'h1FF, 1, 1, "R1");
    t_ip(32'h200, 1, 0, "R1");
    t_ip(32'h150, 0, 0, "R1");
    t_addr(32'h150, 0, "R1");
    wr(ra(2,0), 32'h1);
    t_addr(32'h150, 1, "R1");
    t_ip(32'h150, 1, 0, "R1");

    // R2 masked data compare
    wr(ra(3,0), 32'h0000_5500);
    wr(ra(4,0), 32'h0000_FF00);
    wr(ra(7,0), 32'h1 | (32'd3 << 8));
    t_dat(32'h1234_5578, 1, 1, "R2");
    t_dat(32'h1234_4478, 1, 0, "R2");
    t_dat(32'h1234_5578, 0, 0, "R2");
    wr(ra(4,1), 32'h0);
    wr(ra(7,0), 32'h1 | (32'd4 << 8));
    t_dat(32'hDEAD_BEEF, 1, 1, "R2");
    // R7 disabled breakpoint
    wr(ra(7,0), 32'd3 << 8);
    t_dat(32'h0000_5500, 1, 0, "R7");
    // R3 selector 0 is no event
    wr(ra(7,0), 32'h1);
    t_dat(32'h0000_5500, 1, 0, "R3");
    t_ad(32'h150, 32'h5500, 0, "R3");

    // R4 counter, limit 3, hold
    wr(ra(6,0), 32'd3);
    wr(ra(5,0), 32'd1);
    wr(ra(7,0), 32'h1 | (32'd5 << 8));
    t_clr("R9");
    t_addr(32'h120, 0, "R4");
    t_addr(32'h300, 0, "R4");
    t_addr(32'h130, 0, "R4");
    t_addr(32'h140, 0, "R4");
    t_idle(1, "R4");
    t_idle(0, "R4");
    t_addr(32'h150, 0, "R5");
    t_idle(0, "R5");
    // R9 clear restarts the count
    t_clr("R9");
    t_addr(32'h150, 0, "R9");
    t_addr(32'h150, 0, "R9");
    t_addr(32'h150, 0, "R9");
    t_idle(1, "R9");
    // R5 restart mode
    wr(ra(5,0), 32'd1 | (32'd1 << 16));
    t_clr("R5");
    for (int k = 0; k < 2; k++) begin
      t_addr(32'h150, 0, "R5");
      t_addr(32'h150, 0, "R5");
      t_addr(32'h150, 0, "R5");
      t_idle(1, "R5");
    end
    // R4 zero limit never pulses
    wr(ra(6,0), 32'd0);
    t_clr("R4");
    for (int k = 0; k < 4; k++) t_addr(32'h150, 0, "R4");
    t_idle(0, "R4");
    t_idle(0, "R4");

    // R6 two-stage chain
    wr(ra(6,0), 32'd2);
    wr(ra(5,0), 32'd1 | (32'd1 << 16));
    wr(ra(6,1), 32'd2);
    wr(ra(5,1), 32'd5);
    wr(ra(7,0), 32'h1 | (32'd6 << 8));
    t_clr("R6");
    t_addr(32'h150, 0, "R6");
    t_addr(32'h150, 0, "R6");
    t_idle(0, "R6");
    t_addr(32'h150, 0, "R6");
    t_addr(32'h150, 0, "R6");
    t_idle(0, "R6");
    t_idle(1, "R6");
    t_idle(0, "R6");

    // R3 AND combination (code 7 = window0 & matcher0)
    wr(ra(5,0), 32'd7 | (32'd1 << 16));
    wr(ra(6,0), 32'd1);
    wr(ra(7,0), 32'h1 | (32'd5 << 8));
    t_clr("R3");
    t_ad(32'h150, 32'h5500, 0, "R3");
    t_idle(1, "R3");
    t_addr(32'h150, 0, "R3");
    t_idle(0, "R3");
    t_dat(32'h5500, 1, 0, "R3");
    t_idle(0, "R3");

    // R8 trace set/clear
    wr(ra(7,0), (32'd3 << 24) | (32'd1 << 16));
    tr_model = 1'b1;
    t_addr(32'h150, 0, "R8");
    t_idle(0, "R8");
    tr_model = 1'b0;
    t_dat(32'h5500, 1, 0, "R8");
    t_ad(32'h150, 32'h5500, 0, "R8");
    tr_model = 1'b1;
    t_addr(32'h150, 0, "R8");
    t_clr("R9");
    t_idle(0, "R9");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule